// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides whether a CPU enters its interrupt routine, and then carries out that entry. The CPU checks for a request only when an instruction completes. At that point, if interrupts are enabled and either the input-ready or the output-ready device flag is high, the block sets its pending flag. While the pending flag is set, the block runs three steps in place of the next fetch:

1. It lowers the stack pointer by one.
2. It writes the current program counter into memory at the new stack pointer.
3. It pulses the acknowledge output, loads the vector address into the program counter and turns interrupts off.

The program counter and the stack pointer sit outside the block. The block reads their present values and drives a write strobe and a new value for each. Memory is reached through a single write port. While the pending flag is clear, the fetch-enable output is high and the CPU runs its normal instruction cycles.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the pending flag and the enable flag are 0, fetch enable is 1, and the stack-pointer write, memory write, program-counter write and acknowledge outputs are all 0.
- R2: The pending flag becomes 1 at the clock edge that ends a cycle in which the end-of-instruction strobe, the enable flag and at least one device flag are all 1. It never becomes 1 otherwise, including when a device flag is high without the strobe.
- R3: While the pending flag is 0, fetch enable is 1 and the block drives no write and no acknowledge. While it is 1, fetch enable is 0.
- R4: In the first cycle with the pending flag set, the stack-pointer write is 1 for exactly that cycle and the new stack pointer value is the present value minus one. The value 0 wraps to 4095 (12-bit pointer).
- R5: In the second cycle, the memory write is 1 for exactly that cycle, with the address equal to the present stack pointer and the data equal to the present program counter.
- R6: In the third cycle, the acknowledge output is a single-cycle pulse, together with the program-counter write carrying the vector address. At most one of the stack, memory and acknowledge strobes is high in any cycle.
- R7: After the third cycle, the pending flag and the enable flag are both 0 and fetch enable is 1 again.
- R8: The enable flag is set by the enable-set input and cleared by the enable-clear input. When both are high in the same cycle, clearing wins.
- R9: The strobe and device flags are ignored while the sequence runs, so the sequence is not restarted or lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | End-of-instruction strobe |
| inFlag | input | 1 | Input device ready flag |
| outFlag | input | 1 | Output device ready flag |
| ienSet | input | 1 | Turn interrupts on |
| ienClr | input | 1 | Turn interrupts off |
| vecAddr | input | 12 | Routine vector address |
| pcIn | input | 12 | Present program counter |
| spIn | input | 12 | Present stack pointer |
| pcWe | output | 1 | Program counter write strobe |
| pcNew | output | 12 | Program counter value to write |
| spWe | output | 1 | Stack pointer write strobe |
| spNew | output | 12 | Stack pointer value to write |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 12 | Memory write address |
| memData | output | 12 | Memory write data |
| intAck | output | 1 | Interrupt acknowledge pulse |
| fetchEn | output | 1 | Normal fetch allowed |
| intPending | output | 1 | Pending flag |
| intEnable | output | 1 | Enable flag |

## Verification
The assertions assume that the surrounding CPU writes the stack pointer back on the cycle after the stack-pointer write strobe. They also assume it does not assert the end-of-instruction strobe while fetch is held off.

The bench meets the first condition by modelling the stack register: it updates `spIn` from `spNew` before the push step is sampled. The only place it holds the strobe high during a sequence is the test that checks the strobe is ignored there.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  parameter int ADDR_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_PUSH = 2'd2,
    ST_VEC  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic setPend;
    logic decSp;
    logic pushPc;
    logic loadVec;
  } seqStrobe_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       inFlag,
  input  logic       outFlag,
  input  logic       ienQ,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;
  logic      request;

  assign request = instrDone && ienQ && (inFlag || outFlag);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (request) begin
        strobe.setPend = 1'b1;
        stateNext      = ST_DEC;
      end
      ST_DEC: begin
        strobe.decSp = 1'b1;
        stateNext    = ST_PUSH;
      end
      ST_PUSH: begin
        strobe.pushPc = 1'b1;
        stateNext     = ST_VEC;
      end
      ST_VEC: begin
        strobe.loadVec = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.decSp, strobe.pushPc, strobe.loadVec})); // R6
  AST_PUSH_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decSp |=> strobe.pushPc); // R5
  AST_VEC_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushPc |=> strobe.loadVec); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobe.setPend); // R9
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic          ienSet,
  input  logic          ienClr,
  input  logic [AW-1:0] vecAddr,
  input  logic [AW-1:0] pcIn,
  input  logic [AW-1:0] spIn,
  output logic          ienQ,
  output logic          pendQ,
  output logic          pcWe,
  output logic [AW-1:0] pcNew,
  output logic          spWe,
  output logic [AW-1:0] spNew,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memData,
  output logic          intAck,
  output logic          fetchEn
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      ienQ  <= 1'b0;
    end else begin
      if (strobe.loadVec)      pendQ <= 1'b0;
      else if (strobe.setPend) pendQ <= 1'b1;
      if (strobe.loadVec || ienClr) ienQ <= 1'b0;
      else if (ienSet)              ienQ <= 1'b1;
    end
  end

  assign spWe    = strobe.decSp;
  assign spNew   = spIn - ONE;
  assign memWe   = strobe.pushPc;
  assign memAddr = spIn;
  assign memData = pcIn;
  assign pcWe    = strobe.loadVec;
  assign pcNew   = vecAddr;
  assign intAck  = strobe.loadVec;
  assign fetchEn = !pendQ;

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(ienQ)); // R2
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> (!pendQ && !ienQ && fetchEn)); // R7
  AST_NO_FETCH_IN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (spWe || memWe || intAck) |-> !fetchEn); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck); // R6
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrDone,
  input  logic          inFlag,
  input  logic          outFlag,
  input  logic          ienSet,
  input  logic          ienClr,
  input  logic [AW-1:0] vecAddr,
  input  logic [AW-1:0] pcIn,
  input  logic [AW-1:0] spIn,
  output logic          pcWe,
  output logic [AW-1:0] pcNew,
  output logic          spWe,
  output logic [AW-1:0] spNew,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memData,
  output logic          intAck,
  output logic          fetchEn,
  output logic          intPending,
  output logic          intEnable
);
  seqStrobe_t strobe;
  logic       ienQ;
  logic       pendQ;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .inFlag(inFlag),
    .outFlag(outFlag), .ienQ(ienQ), .strobe(strobe)
  );

  irq_entry_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ienSet(ienSet), .ienClr(ienClr),
    .vecAddr(vecAddr), .pcIn(pcIn), .spIn(spIn), .ienQ(ienQ), .pendQ(pendQ),
    .pcWe(pcWe), .pcNew(pcNew), .spWe(spWe), .spNew(spNew), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .intAck(intAck), .fetchEn(fetchEn)
  );

  assign intPending = pendQ;
  assign intEnable  = ienQ;
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrDone = 0, inFlag = 0, outFlag = 0, ienSet = 0, ienClr = 0;
  logic [11:0] vecAddr = 0, pcIn = 0, spIn = 0;
  logic pcWe, spWe, memWe, intAck, fetchEn, intPending, intEnable;
  logic [11:0] pcNew, spNew, memAddr, memData;
  int testCnt = 0, failCnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .inFlag(inFlag), .outFlag(outFlag),
    .ienSet(ienSet), .ienClr(ienClr), .vecAddr(vecAddr), .pcIn(pcIn), .spIn(spIn),
    .pcWe(pcWe), .pcNew(pcNew), .spWe(spWe), .spNew(spNew), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .intAck(intAck), .fetchEn(fetchEn),
    .intPending(intPending), .intEnable(intEnable)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk(!spWe && !memWe && !pcWe && !intAck, tag,
        {spWe, memWe, pcWe, intAck}, 0);
  endtask

  task automatic enableInts();
    ienSet = 1; @(negedge clk); ienSet = 0;
  endtask

  task automatic testReset();
    chk(intPending == 0 && intEnable == 0, "R1 flags", {intPending, intEnable}, 0);
    chk(fetchEn == 1, "R1 fetchEn", fetchEn, 1);
    quiet("R1 strobes");
  endtask

  task automatic testNoRequest();
    // enable off, flag and strobe high: no entry
    inFlag = 1; instrDone = 1; @(negedge clk);
    instrDone = 0;
    chk(intPending == 0, "R2 no set with enable off", intPending, 0);
    quiet("R3 idle no writes");
    // enable on, flag high, no strobe
    enableInts();
    outFlag = 1; @(negedge clk); @(negedge clk);
    chk(intPending == 0, "R2 no set without strobe", intPending, 0);
    chk(fetchEn == 1, "R3 fetch while idle", fetchEn, 1);
    // strobe with no flag
    inFlag = 0; outFlag = 0; instrDone = 1; @(negedge clk);
    instrDone = 0;
    chk(intPending == 0, "R2 no set without flag", intPending, 0);
    ienClr = 1; @(negedge clk); ienClr = 0;
  endtask

  task automatic runEntry(input bit fi, input bit fo, input logic [11:0] sp,
                          input logic [11:0] pc, input logic [11:0] vec, input bit holdReq);
    logic [11:0] spExp;
    spExp = sp - 12'd1;
    enableInts();
    spIn = sp; pcIn = pc; vecAddr = vec;
    inFlag = fi; outFlag = fo; instrDone = 1;
    @(negedge clk);
    if (!holdReq) begin instrDone = 0; inFlag = 0; outFlag = 0; end
    chk(intPending == 1, "R2 pending set", intPending, 1);
    chk(fetchEn == 0, "R3 fetch held", fetchEn, 0);
    chk(spWe == 1 && spNew == spExp, "R4 sp decrement", spNew, spExp);
    chk(!memWe && !intAck, "R6 only dec step", {memWe, intAck}, 0);
    spIn = spNew;
    @(negedge clk);
    chk(spWe == 0, "R4 sp write one cycle", spWe, 0);
    chk(memWe == 1 && memAddr == spExp, "R5 push addr", memAddr, spExp);
    chk(memData == pc, "R5 push data", memData, pc);
    @(negedge clk);
    chk(memWe == 0, "R5 push one cycle", memWe, 0);
    chk(intAck == 1 && pcWe == 1 && pcNew == vec, "R6 vector load", pcNew, vec);
    @(negedge clk);
    chk(intAck == 0 && pcWe == 0, "R6 ack single pulse", intAck, 0);
    chk(intPending == 0 && intEnable == 0, "R7 flags cleared", {intPending, intEnable}, 0);
    chk(fetchEn == 1, "R7 fetch resumes", fetchEn, 1);
    if (holdReq) begin
      @(negedge clk);
      chk(intPending == 0 && !spWe, "R9 held request ignored", intPending, 0);
      instrDone = 0; inFlag = 0; outFlag = 0;
    end
  endtask

  task automatic testEnableFlag();
    ienSet = 1; ienClr = 1; @(negedge clk);
    ienSet = 0; ienClr = 0;
    chk(intEnable == 0, "R8 clear wins", intEnable, 0);
    enableInts();
    chk(intEnable == 1, "R8 set", intEnable, 1);
    ienClr = 1; @(negedge clk); ienClr = 0;
    chk(intEnable == 0, "R8 clear", intEnable, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failCnt++; testCnt++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testNoRequest();
    runEntry(1, 0, 12'h200, 12'h123, 12'h004, 0);
    runEntry(0, 1, 12'h000, 12'hABC, 12'h010, 0);
    runEntry(1, 1, 12'hFFF, 12'h7FF, 12'hFF0, 1);
    testEnableFlag();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule